// File: doc/BRIEF.md
# Integer Execute Stage

This block is the single-cycle, purely combinational arithmetic stage of a 32-bit load/store processor with 32 general registers. The decode stage gives it an operation selector and the raw instruction word. The register file gives it the values of the two registers that the instruction's source fields name. In the same cycle the block returns the result, the index of the destination register, a write enable, an illegal-instruction flag and a halt request.

The block reads three register fields and the immediate field from the instruction word. Bit 31 picks between the register-register form and the register-immediate form. Whether the 16-bit immediate is sign-extended or zero-extended depends on the operation. Two build parameters control hardware options. `HAS_BARREL` adds a full barrel shifter. Without it, the only shifts allowed are right shifts by exactly one. `HAS_SEXT` adds the byte and halfword sign extender. Operations that need missing hardware raise the illegal flag, so trap logic elsewhere can emulate them.

Top module: `exec_unit`

## Requirements
- R1: When instruction bit 31 is 1 (register form), the destination is bits 15:11 and the two sources are bits 25:21 (first) and 20:16 (second). When bit 31 is 0 (immediate form), the destination is bits 20:16, the source is bits 25:21, and the second operand is taken from the immediate in bits 15:0.
- R2: A source field equal to 0 reads as zero, whatever value is on its operand input. A destination field equal to 0 keeps `wr_en` low.
- R3: Add, subtract, and, or, xor, nor and xnor produce the 32-bit wrapped arithmetic or bitwise result of their two operands.
- R4: In immediate form, add and the equal, not-equal, signed-greater and signed-greater-or-equal compares sign-extend the immediate. And, or, xor, nor, xnor and the two unsigned compares zero-extend it.
- R5: And-high and or-high place the immediate in bits 31:16 with zeros below. They then AND or OR that value with the source.
- R6: Every compare writes 1 when its condition holds and 0 when it does not.
- R7: The register-form shift amount is the low 5 bits of the second operand. The immediate-form shift amount is instruction bits 4:0. Shift-left is logical, shift-right-arithmetic replicates bit 31, and shift-right-logical fills with zeros.
- R8: With `HAS_BARREL`=0, every shift-left is illegal. A right shift is illegal unless its amount is exactly 1, and a right shift by 1 still gives the correct result.
- R9: Sign-extend-byte copies bit 7 into bits 31:8, and sign-extend-halfword copies bit 15 into bits 31:16. With `HAS_SEXT`=0, both are illegal.
- R10: A register-form AND whose three register fields are all 0 sets `halt_req`. It keeps `wr_en` and `illegal` low and drives a zero result.
- R11: The following are illegal: a selector value of 20 or more, subtract or either sign-extend in immediate form, and and-high or or-high in register form. Whenever `illegal` is high, `wr_en` is low and the result is zero.
- R12: `op_sel` encoding: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 xnor, 7 and-high, 8 or-high, 9 cmp-eq, 10 cmp-ne, 11 cmp-gt signed, 12 cmp-ge signed, 13 cmp-gt unsigned, 14 cmp-ge unsigned, 15 shift-left, 16 shift-right-arith, 17 shift-right-logical, 18 sext-byte, 19 sext-half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Decoded operation selector (R12 encoding) |
| instr_word | input | 32 | Raw instruction: format bit, register fields, immediate |
| rs_a_val | input | 32 | Register-file value for the field in bits 25:21 |
| rs_b_val | input | 32 | Register-file value for the field in bits 20:16 |
| res_val | output | 32 | Computed result |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Result should be written to `dst_idx` |
| illegal | output | 1 | Operation is undefined or needs absent hardware |
| halt_req | output | 1 | Halt request decoded |

## Verification
The assertions assume the inputs are stable whenever the combinational checks run. They also assume `op_sel` is a 5-bit value that is never unknown. Both assumptions hold because the bench changes inputs only after a rising edge and checks outputs at the falling edge. The bench instantiates two builds, one with every option and one with neither. The same stimulus drives both. The stimulus sweeps every selector value, including the undefined ones, in both formats. It crosses this sweep with boundary data patterns and varied register fields. It then sweeps all 32 shift amounts in both shift forms, and adds targeted vectors for register 0 and the halt pattern.

// File: rtl/exec_pkg.sv
// Shared constants, the operation selector type and classification helpers
// for the integer execute stage. Assumes a 32-bit datapath and 5-bit
// register indices.
package exec_pkg;

    localparam int DATA_W  = 32;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int OP_W    = 5;

    // Instruction field positions the neighbouring decode stage relies on.
    localparam int FMT_BIT  = 31;
    localparam int FA_LSB   = 21;
    localparam int FB_LSB   = 16;
    localparam int FD_LSB   = 11;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_AND   = 5'd2,
        OP_OR    = 5'd3,
        OP_XOR   = 5'd4,
        OP_NOR   = 5'd5,
        OP_XNOR  = 5'd6,
        OP_ANDHI = 5'd7,
        OP_ORHI  = 5'd8,
        OP_CEQ   = 5'd9,
        OP_CNE   = 5'd10,
        OP_CGT   = 5'd11,
        OP_CGE   = 5'd12,
        OP_CGTU  = 5'd13,
        OP_CGEU  = 5'd14,
        OP_SLL   = 5'd15,
        OP_SRA   = 5'd16,
        OP_SRL   = 5'd17,
        OP_SXB   = 5'd18,
        OP_SXH   = 5'd19
    } exec_op_e;

    localparam int OP_COUNT = 20;

    function automatic logic op_is_cmp(input exec_op_e op);
        return (op >= OP_CEQ) && (op <= OP_CGEU);
    endfunction

    function automatic logic op_is_shift(input exec_op_e op);
        return (op == OP_SLL) || (op == OP_SRA) || (op == OP_SRL);
    endfunction

    function automatic logic op_is_sext(input exec_op_e op);
        return (op == OP_SXB) || (op == OP_SXH);
    endfunction

    // Immediate-form operations whose 16-bit immediate is sign-extended.
    function automatic logic op_imm_signed(input exec_op_e op);
        return (op == OP_ADD) || (op == OP_CEQ) || (op == OP_CNE) ||
               (op == OP_CGT) || (op == OP_CGE);
    endfunction

endpackage

// File: rtl/exec_operand.sv
// Operand former: extracts the register fields, forces register 0 to read
// as zero, builds the second operand (register value or extended / shifted
// immediate) and the shift amount. Assumes instr_word is the full word.
module exec_operand
    import exec_pkg::*;
(
    input  logic [31:0]        instr_word,
    input  exec_op_e           op,
    input  logic [DATA_W-1:0]  rs_a_val,
    input  logic [DATA_W-1:0]  rs_b_val,
    output logic               fmt_rr,
    output logic [REG_W-1:0]   src_a_idx,
    output logic [REG_W-1:0]   src_b_idx,
    output logic [REG_W-1:0]   dst_idx,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b,
    output logic [SHAMT_W-1:0] shamt
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [IMM_W-1:0]  imm_raw;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_reg;

    // Field extraction by format bit.
    always_comb begin
        fmt_rr    = instr_word[FMT_BIT];
        src_a_idx = instr_word[FA_LSB +: REG_W];
        src_b_idx = instr_word[FB_LSB +: REG_W];
        dst_idx   = fmt_rr ? instr_word[FD_LSB +: REG_W] : src_b_idx;
        imm_raw   = instr_word[IMM_W-1:0];
    end

    // Register 0 reads as zero on both source ports.
    always_comb begin
        opnd_a = (src_a_idx == '0) ? '0 : rs_a_val;
        b_reg  = (src_b_idx == '0) ? '0 : rs_b_val;
    end

    // Immediate extension chosen per operation.
    always_comb begin
        if (op == OP_ANDHI || op == OP_ORHI)
            imm_ext = {imm_raw, {EXT_W{1'b0}}};
        else if (op_imm_signed(op))
            imm_ext = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
        else
            imm_ext = {{EXT_W{1'b0}}, imm_raw};
    end

    // Second operand and shift amount.
    always_comb begin
        opnd_b = fmt_rr ? b_reg : imm_ext;
        shamt  = fmt_rr ? b_reg[SHAMT_W-1:0] : imm_raw[SHAMT_W-1:0];
    end

endmodule

// File: rtl/exec_alu.sv
// Arithmetic, bitwise, high-half and compare unit. Purely combinational;
// assumes operands were already formed (extension and r0 handling done).
module exec_alu
    import exec_pkg::*;
(
    input  exec_op_e          op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] alu_res
);

    logic cond;

    // Compare condition evaluation.
    always_comb begin
        unique case (op)
            OP_CEQ:  cond = (opnd_a == opnd_b);
            OP_CNE:  cond = (opnd_a != opnd_b);
            OP_CGT:  cond = ($signed(opnd_a) >  $signed(opnd_b));
            OP_CGE:  cond = ($signed(opnd_a) >= $signed(opnd_b));
            OP_CGTU: cond = (opnd_a >  opnd_b);
            OP_CGEU: cond = (opnd_a >= opnd_b);
            default: cond = 1'b0;
        endcase
    end

    // Result selection for non-shift operations.
    always_comb begin
        if (op_is_cmp(op)) begin
            alu_res = {{(DATA_W-1){1'b0}}, cond};
        end else begin
            unique case (op)
                OP_ADD:            alu_res = opnd_a + opnd_b;
                OP_SUB:            alu_res = opnd_a - opnd_b;
                OP_AND, OP_ANDHI:  alu_res = opnd_a & opnd_b;
                OP_OR,  OP_ORHI:   alu_res = opnd_a | opnd_b;
                OP_XOR:            alu_res = opnd_a ^ opnd_b;
                OP_NOR:            alu_res = ~(opnd_a | opnd_b);
                OP_XNOR:           alu_res = ~(opnd_a ^ opnd_b);
                default:           alu_res = '0;
            endcase
        end
    end

endmodule

// File: rtl/exec_shift.sv
// Shifter. With HAS_BARREL a full 0..31 shifter; otherwise only a one-bit
// right shift, with every other shift reported as a trap.
module exec_shift
    import exec_pkg::*;
#(
    parameter bit HAS_BARREL = 1'b1
) (
    input  exec_op_e           op,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  sh_res,
    output logic               sh_trap
);

    generate
        if (HAS_BARREL) begin : g_barrel
            // Full barrel shift in all three directions.
            always_comb begin
                sh_trap = 1'b0;
                unique case (op)
                    OP_SLL:  sh_res = opnd_a << shamt;
                    OP_SRA:  sh_res = DATA_W'($signed(opnd_a) >>> shamt);
                    OP_SRL:  sh_res = opnd_a >> shamt;
                    default: sh_res = '0;
                endcase
            end
        end else begin : g_single
            // One-bit right shift only; anything else traps.
            always_comb begin
                sh_trap = op_is_shift(op) &&
                          ((op == OP_SLL) || (shamt != SHAMT_W'(1)));
                unique case (op)
                    OP_SRA:  sh_res = {opnd_a[DATA_W-1], opnd_a[DATA_W-1:1]};
                    OP_SRL:  sh_res = {1'b0, opnd_a[DATA_W-1:1]};
                    default: sh_res = '0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/exec_unit.sv
// Integer execute stage top. Combines operand forming, ALU, shifter and the
// optional sign extender, decides legality and halt, and gates the write.
// Purely combinational: the host pipeline supplies clocking and reset.
// Assumes rs_a_val / rs_b_val belong to the registers named by bits 25:21
// and 20:16 of instr_word.
module exec_unit
    import exec_pkg::*;
#(
    parameter bit HAS_BARREL = 1'b1,
    parameter bit HAS_SEXT   = 1'b1
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [31:0]       instr_word,
    input  logic [DATA_W-1:0] rs_a_val,
    input  logic [DATA_W-1:0] rs_b_val,
    output logic [DATA_W-1:0] res_val,
    output logic [REG_W-1:0]  dst_idx,
    output logic              wr_en,
    output logic              illegal,
    output logic              halt_req
);

    exec_op_e           op;
    logic               fmt_rr;
    logic [REG_W-1:0]   src_a_idx;
    logic [REG_W-1:0]   src_b_idx;
    logic [DATA_W-1:0]  opnd_a;
    logic [DATA_W-1:0]  opnd_b;
    logic [SHAMT_W-1:0] shamt;
    logic [DATA_W-1:0]  alu_res;
    logic [DATA_W-1:0]  sh_res;
    logic               sh_trap;
    logic [DATA_W-1:0]  sx_res;
    logic               sx_trap;
    logic               op_known;
    logic               fmt_bad;
    logic               spare_unused;

    assign op           = exec_op_e'(op_sel);
    assign spare_unused = ^instr_word[30:26];

    exec_operand u_operand (
        .instr_word (instr_word),
        .op         (op),
        .rs_a_val   (rs_a_val),
        .rs_b_val   (rs_b_val),
        .fmt_rr     (fmt_rr),
        .src_a_idx  (src_a_idx),
        .src_b_idx  (src_b_idx),
        .dst_idx    (dst_idx),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .shamt      (shamt)
    );

    exec_alu u_alu (
        .op      (op),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .alu_res (alu_res)
    );

    exec_shift #(.HAS_BARREL(HAS_BARREL)) u_shift (
        .op      (op),
        .opnd_a  (opnd_a),
        .shamt   (shamt),
        .sh_res  (sh_res),
        .sh_trap (sh_trap)
    );

    generate
        if (HAS_SEXT) begin : g_sext
            // Byte / halfword sign extension.
            always_comb begin
                sx_trap = 1'b0;
                if (op == OP_SXB)
                    sx_res = {{(DATA_W-8){opnd_a[7]}}, opnd_a[7:0]};
                else
                    sx_res = {{(DATA_W-16){opnd_a[15]}}, opnd_a[15:0]};
            end
        end else begin : g_no_sext
            // No extender: flag the request as a trap.
            always_comb begin
                sx_res  = '0;
                sx_trap = op_is_sext(op);
            end
        end
    endgenerate

    // Legality: known selector, matching format, hardware present.
    always_comb begin
        op_known = (int'(op_sel) < OP_COUNT);
        fmt_bad  = (!fmt_rr && (op == OP_SUB || op_is_sext(op))) ||
                   ( fmt_rr && (op == OP_ANDHI || op == OP_ORHI));
        illegal  = !op_known || fmt_bad || sh_trap || sx_trap;
    end

    // Halt pattern: register-form AND with every register field zero.
    always_comb begin
        halt_req = !illegal && fmt_rr && (op == OP_AND) &&
                   (src_a_idx == '0) && (src_b_idx == '0) && (dst_idx == '0);
    end

    // Final result select and write gating.
    always_comb begin
        if (illegal || halt_req)
            res_val = '0;
        else if (op_is_shift(op))
            res_val = sh_res;
        else if (op_is_sext(op))
            res_val = sx_res;
        else
            res_val = alu_res;
        wr_en = !illegal && !halt_req && (dst_idx != '0);
    end

    // Output relations checked whenever inputs settle.
    always_comb begin
        // R11
        trap_gate_chk: assert (!(illegal && (wr_en || res_val != '0)));
        // R10
        halt_excl_chk: assert (!(halt_req && (wr_en || illegal)));
        // R2
        r0_dest_chk: assert (!(dst_idx == '0 && wr_en));
        // R6
        cmp_range_chk: assert (!(op_known && op_is_cmp(op) && !illegal &&
                                 res_val[DATA_W-1:1] != '0));
        // R5
        hi_low_chk: assert (!(!illegal && op == OP_ANDHI &&
                              res_val[IMM_W-1:0] != '0));
        // R5
        orhi_low_chk: assert (!(!illegal && op == OP_ORHI &&
                                res_val[IMM_W-1:0] != opnd_a[IMM_W-1:0]));
        // R8
        lite_sll_chk: assert (HAS_BARREL || op != OP_SLL || illegal);
        // R9
        lite_sext_chk: assert (HAS_SEXT || !op_is_sext(op) || illegal);
    end

endmodule

// File: tb/exec_unit_tb_top.sv
// Self-checking bench: a full build and a minimal build driven in parallel,
// compared with an arithmetic model derived from the requirements.
module exec_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] instr_word = '0;
    logic [31:0] rs_a_val = '0;
    logic [31:0] rs_b_val = '0;

    logic [31:0] f_res, l_res;
    logic [4:0]  f_dst, l_dst;
    logic        f_wr, l_wr, f_ill, l_ill, f_halt, l_halt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_unit #(.HAS_BARREL(1'b1), .HAS_SEXT(1'b1)) dut_i (
        .op_sel(op_sel), .instr_word(instr_word),
        .rs_a_val(rs_a_val), .rs_b_val(rs_b_val),
        .res_val(f_res), .dst_idx(f_dst), .wr_en(f_wr),
        .illegal(f_ill), .halt_req(f_halt)
    );

    exec_unit #(.HAS_BARREL(1'b0), .HAS_SEXT(1'b0)) dut_lite_i (
        .op_sel(op_sel), .instr_word(instr_word),
        .rs_a_val(rs_a_val), .rs_b_val(rs_b_val),
        .res_val(l_res), .dst_idx(l_dst), .wr_en(l_wr),
        .illegal(l_ill), .halt_req(l_halt)
    );

    // Model: {halt, illegal, wr_en, dst[4:0], result[31:0]}
    function automatic logic [39:0] model(input bit full, input logic [4:0] op,
                                          input logic [31:0] iw,
                                          input logic [31:0] a, input logic [31:0] b);
        logic rr = iw[31];
        logic [4:0] ra = iw[25:21];
        logic [4:0] rb = iw[20:16];
        logic [4:0] rd = rr ? iw[15:11] : rb;
        logic [15:0] imm = iw[15:0];
        logic [31:0] va = (ra == 0) ? 32'h0 : a;
        logic [31:0] vb = (rb == 0) ? 32'h0 : b;
        logic sgn = (op == 0) || (op >= 9 && op <= 12);
        logic [31:0] y = rr ? vb : (sgn ? {{16{imm[15]}}, imm} : {16'h0, imm});
        logic [4:0] sh = rr ? vb[4:0] : imm[4:0];
        logic [31:0] r = 32'h0;
        logic ill = 1'b0;
        logic hlt;
        logic wr;
        case (op)
            5'd0:  r = va + y;
            5'd1:  r = va - y;
            5'd2:  r = va & y;
            5'd3:  r = va | y;
            5'd4:  r = va ^ y;
            5'd5:  r = ~(va | y);
            5'd6:  r = ~(va ^ y);
            5'd7:  r = va & {imm, 16'h0};
            5'd8:  r = va | {imm, 16'h0};
            5'd9:  r = {31'h0, va == y};
            5'd10: r = {31'h0, va != y};
            5'd11: r = {31'h0, $signed(va) > $signed(y)};
            5'd12: r = {31'h0, $signed(va) >= $signed(y)};
            5'd13: r = {31'h0, va > y};
            5'd14: r = {31'h0, va >= y};
            5'd15: r = va << sh;
            5'd16: r = 32'($signed(va) >>> sh);
            5'd17: r = va >> sh;
            5'd18: r = {{24{va[7]}}, va[7:0]};
            5'd19: r = {{16{va[15]}}, va[15:0]};
            default: ill = 1'b1;
        endcase
        if (!rr && (op == 1 || op == 18 || op == 19)) ill = 1'b1;
        if (rr && (op == 7 || op == 8)) ill = 1'b1;
        if (!full && (op == 15 || ((op == 16 || op == 17) && sh != 5'd1))) ill = 1'b1;
        if (!full && (op == 18 || op == 19)) ill = 1'b1;
        hlt = !ill && rr && op == 2 && ra == 0 && rb == 0 && rd == 0;
        if (ill || hlt) r = 32'h0;
        wr = !ill && !hlt && rd != 0;
        return {hlt, ill, wr, rd, r};
    endfunction

    function automatic string tag_of(input logic [4:0] op, input logic rr, input bit full);
        if (op >= 20) return "R11";
        if (op <= 6 || op >= 9 && op <= 14) begin
            if (!rr && (op == 0 || op >= 2)) return "R4";
        end
        if (op <= 6) return "R3";
        if (op <= 8) return "R5";
        if (op <= 14) return "R6";
        if (op <= 17) return full ? "R7" : "R8";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d iw=%h got=%h exp=%h", tag, op_sel, instr_word, got, exp);
        end
    endtask

    // Drive one vector after a rising edge, check both builds at the falling edge.
    task automatic apply(input string tag, input logic [4:0] op, input logic [31:0] iw,
                         input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        op_sel = op; instr_word = iw; rs_a_val = a; rs_b_val = b;
        @(negedge clk);
        check(tag, {f_halt, f_ill, f_wr, f_dst, f_res}, model(1'b1, op, iw, a, b));
        check(tag, {l_halt, l_ill, l_wr, l_dst, l_res}, model(1'b0, op, iw, a, b));
    endtask

    function automatic logic [31:0] pat(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h1234_8678;
            6: return 32'hA5A5_A5A5;
            default: return 32'h0000_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] mk_rr(input logic [4:0] ra, input logic [4:0] rb,
                                          input logic [4:0] rd);
        return {1'b1, 5'b10110, ra, rb, rd, 11'h5A3};
    endfunction

    function automatic logic [31:0] mk_ri(input logic [4:0] ra, input logic [4:0] rb,
                                          input logic [15:0] imm);
        return {1'b0, 5'b01001, ra, rb, imm};
    endfunction

    initial begin
        // Reset-state check: all-zero inputs decode as add r0,r0 immediate 0.
        @(negedge clk);
        check("R2", {f_halt, f_ill, f_wr, f_dst, f_res}, 40'h0);

        // R1 field placement, both forms.
        apply("R1", 5'd0, mk_rr(5'd3, 5'd7, 5'd12), 32'd100, 32'd23);
        apply("R1", 5'd0, mk_ri(5'd3, 5'd9, 16'd5), 32'd100, 32'd999);
        // R2 register 0 sources and destination.
        apply("R2", 5'd3, mk_rr(5'd0, 5'd4, 5'd8), 32'hDEAD_BEEF, 32'h10);
        apply("R2", 5'd3, mk_rr(5'd4, 5'd0, 5'd8), 32'h10, 32'hDEAD_BEEF);
        apply("R2", 5'd0, mk_ri(5'd4, 5'd0, 16'h7), 32'h10, 32'h0);
        // R10 halt pattern and near misses.
        apply("R10", 5'd2, 32'h8000_0000, 32'h1234, 32'h5678);
        apply("R10", 5'd2, mk_rr(5'd0, 5'd0, 5'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply("R10", 5'd2, mk_rr(5'd0, 5'd0, 5'd1), 32'h1, 32'h1);
        apply("R10", 5'd2, mk_ri(5'd0, 5'd0, 16'h0), 32'h1, 32'h1);
        // R12 selector boundary.
        apply("R12", 5'd19, mk_rr(5'd2, 5'd3, 5'd4), 32'h0000_8001, 32'h0);
        apply("R12", 5'd20, mk_rr(5'd2, 5'd3, 5'd4), 32'h0000_8001, 32'h0);

        // Sweep every selector, both forms, crossed data patterns.
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [4:0] ra = 5'(i * 3 + 1);
                    logic [4:0] rb = 5'(j * 5 + 2);
                    logic [4:0] rd = 5'(i + j + 3);
                    apply(tag_of(5'(op), 1'b1, 1'b1), 5'(op), mk_rr(ra, rb, rd), pat(i), pat(j));
                    apply(tag_of(5'(op), 1'b0, 1'b1), 5'(op),
                          mk_ri(ra, rb, pat(j)[15:0] ^ pat(i)[31:16]), pat(i), pat(j));
                end
            end
        end

        // R7 / R8 every shift amount, both forms; high amount bits set too.
        for (int sh = 0; sh < 32; sh++) begin
            for (int op = 15; op <= 17; op++) begin
                apply("R7", 5'(op), mk_rr(5'd6, 5'd7, 5'd9), 32'hC3A5_0F81,
                      {27'h5A5A5A5, 5'(sh)});
                apply("R8", 5'(op), mk_ri(5'd6, 5'd7, {11'h4F3, 5'(sh)}),
                      32'h93A5_0F80, 32'hFFFF_FFFF);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule